// File: doc/BRIEF.md
# Calendar Alarm Comparator with Latched and Pulsed Interrupt

This block watches a calendar time vector supplied by an external clock counter and compares it with a set of stored alarm fields. The fields are second, minute, hour, date, month and day of week. Each alarm field carries its own enable bit. A field that is not enabled matches any value. When every enabled field equals the current time, the block records an alarm event. The event sets a status bit and pulls an active-low interrupt line.

A mode input picks one of two interrupt behaviours. In latched mode the interrupt stays asserted for as long as the status bit is set, and software must clear the status. In pulsed mode every new match asserts the interrupt for a fixed number of 1 kHz ticks, 250 by default, which gives a 250 ms pulse. Pulsed mode recurs on each match. Software clears the status by writing a zero to it. When the auto-clear option is on, a read of the status also clears it. While the system runs on backup power the alarm is inert.

Top module: `cal_alarm`

## Requirements
- R1: Alarm field i occupies bits [8i+7:8i] of `alarm_fields`, and time field i occupies bits [7i+6:7i] of `now_fields`. The field order is 0=second, 1=minute, 2=hour, 3=date, 4=month and 5=day of week. Bit 7 of an alarm field enables that field. An enabled field matches when its bits [6:0] equal the time field. A disabled field always matches.
- R2: When no alarm field has its enable bit set, no alarm event occurs, whatever the time.
- R3: With `pulse_mode`=0, an alarm event sets `alm_stat` at the next clock edge. `irq_n` is then low whenever `alm_stat` is 1.
- R4: A cycle with `stat_wr`=1 and `stat_wr_val`=0 clears `alm_stat` at the next edge. A write with `stat_wr_val`=1 leaves the status unchanged.
- R5: A cycle with `stat_rd`=1 clears `alm_stat` only if `auto_clr`=1. With `auto_clr`=0 a read has no effect.
- R6: With `pulse_mode`=1, an alarm event sets `alm_stat`. `irq_n` goes low from the next cycle and stays low until PULSE_MS cycles with `tick_1k`=1 have passed. In pulsed mode `irq_n` does not depend on `alm_stat`.
- R7: An event happens only in the cycle where the match condition becomes true. A match that is held for many cycles gives a single event, so clearing the status during a held match keeps it clear.
- R8: A new event during a running pulse restarts the full PULSE_MS tick count.
- R9: While `battery`=1 there are no events, `irq_n` is held high and any running pulse is dropped. `alm_stat` keeps its value.
- R10: When an event and a clear request fall in the same cycle, the event wins and `alm_stat` ends up 1.
- R11: After reset `irq_n` is 1 and `alm_stat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle 1 kHz enable that times the pulse |
| now_fields | input | NUM_FIELDS*(FIELD_W-1) (42) | Current calendar time, seven bits per field |
| alarm_fields | input | NUM_FIELDS*FIELD_W (48) | Alarm fields, enable bit in each field's MSB |
| pulse_mode | input | 1 | 0 selects latched mode, 1 selects pulsed mode |
| auto_clr | input | 1 | Lets a status read clear the status |
| battery | input | 1 | System is on backup power |
| stat_wr | input | 1 | Status write strobe |
| stat_wr_val | input | 1 | Value written to the status bit |
| stat_rd | input | 1 | Status read strobe |
| irq_n | output | 1 | Active-low alarm interrupt |
| alm_stat | output | 1 | Alarm status bit |

## Verification
The status bit can be set by a new match and cleared by a write or a read in the same clock. These two can collide. The bench makes this happen by moving the time onto the alarm value in the same cycle that it pulses a zero write or an auto-clear read. It then expects the status to read 1 afterwards. A second collision occurs in pulsed mode, where a fresh match lands while the pulse counter is running. Here the bench leaves the time, comes back to the alarm value mid-pulse, and checks that `irq_n` stays low for a full new window counted from the second match. A behavioural model is compared with the outputs on every clock.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

  typedef enum logic {
    ALM_LATCH = 1'b0,
    ALM_PULSE = 1'b1
  } alm_mode_e;

  // Counter width that can hold values from 0 up to n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NF = 6,
  parameter int FW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               battery,
  input  logic [NF*(FW-1)-1:0] now_v,
  input  logic [NF*FW-1:0]   alm_v,
  output logic               hit,
  output logic               evt
);
  localparam int TW = FW - 1;

  logic [NF-1:0] fld_en;
  logic [NF-1:0] fld_ok;
  logic          hit_q;
  logic          any_en;

  // A field passes when disabled, or when its value equals the time
  function automatic logic field_pass(input logic [FW-1:0] a, input logic [TW-1:0] t);
    return !a[FW-1] || (a[TW-1:0] == t);
  endfunction

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign fld_en[i] = alm_v[i*FW + FW - 1];
    assign fld_ok[i] = field_pass(alm_v[i*FW +: FW], now_v[i*TW +: TW]);
  end

  assign any_en = |fld_en;
  assign hit    = any_en && (&fld_ok) && !battery;
  assign evt    = hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  a_r2_no_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_en == '0) |-> !evt);
  a_r7_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  a_r9_no_evt_batt: assert property (@(posedge clk) disable iff (!rst_n)
    battery |-> !evt);

endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse
  import alarm_pkg::*;
#(
  parameter int PULSE_MS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  logic kill,
  output logic active
);
  localparam int CW = cnt_width(PULSE_MS);
  localparam logic [CW-1:0] FULL = CW'(PULSE_MS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (kill)                  cnt <= '0;
    else if (load)                  cnt <= FULL;
    else if (tick && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  a_r6_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !kill) |=> (cnt == FULL));
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !kill) |=> $stable(cnt));

endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= 1'b0;
    else if (set) stat <= 1'b1;
    else if (clr) stat <= 1'b0;
  end

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> stat);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !stat);

endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import alarm_pkg::*;
#(
  parameter int NUM_FIELDS = 6,
  parameter int FIELD_W    = 8,
  parameter int PULSE_MS   = 250
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tick_1k,
  input  logic [NUM_FIELDS*(FIELD_W-1)-1:0] now_fields,
  input  logic [NUM_FIELDS*FIELD_W-1:0]     alarm_fields,
  input  logic                              pulse_mode,
  input  logic                              auto_clr,
  input  logic                              battery,
  input  logic                              stat_wr,
  input  logic                              stat_wr_val,
  input  logic                              stat_rd,
  output logic                              irq_n,
  output logic                              alm_stat
);
  alm_mode_e mode;
  logic      hit;
  logic      evt;
  logic      clr_req;
  logic      pulse_load;
  logic      pulse_on;

  assign mode       = alm_mode_e'(pulse_mode);
  assign clr_req    = (stat_wr && !stat_wr_val) || (stat_rd && auto_clr);
  assign pulse_load = evt && (mode == ALM_PULSE);

  alarm_match #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .battery (battery),
    .now_v   (now_fields),
    .alm_v   (alarm_fields),
    .hit     (hit),
    .evt     (evt)
  );

  alarm_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (evt),
    .clr   (clr_req),
    .stat  (alm_stat)
  );

  alarm_pulse #(.PULSE_MS(PULSE_MS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1k),
    .load   (pulse_load),
    .kill   (battery),
    .active (pulse_on)
  );

  always_comb begin
    if (battery)                irq_n = 1'b1;
    else if (mode == ALM_PULSE) irq_n = !pulse_on;
    else                        irq_n = !alm_stat;
  end

  a_r9_batt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    battery |-> irq_n);
  a_r3_latch_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!battery && mode == ALM_LATCH && alm_stat) |-> !irq_n);
  a_r3_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && hit) |=> alm_stat);
  a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !stat_wr && stat_rd && !auto_clr) |=> $stable(alm_stat));

endmodule

// File: tb/cal_alarm_test.sv
module cal_alarm_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int PMS = 250;

  logic clk = 0, rst_n = 0, tick_1k = 0;
  logic [NF*(FW-1)-1:0] now_fields = '0;
  logic [NF*FW-1:0]     alarm_fields = '0;
  logic pulse_mode = 0, auto_clr = 0, battery = 0;
  logic stat_wr = 0, stat_wr_val = 0, stat_rd = 0;
  logic irq_n, alm_stat;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R11";
  int m_prev = 0, m_stat = 0, m_cnt = 0;

  cal_alarm #(.NUM_FIELDS(NF), .FIELD_W(FW), .PULSE_MS(PMS)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .now_fields(now_fields),
    .alarm_fields(alarm_fields), .pulse_mode(pulse_mode), .auto_clr(auto_clr),
    .battery(battery), .stat_wr(stat_wr), .stat_wr_val(stat_wr_val),
    .stat_rd(stat_rd), .irq_n(irq_n), .alm_stat(alm_stat));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference match rule, field by field
  function automatic int ref_hit();
    int any = 0, ok = 1;
    for (int i = 0; i < NF; i++) begin
      if (alarm_fields[i*FW + 7]) begin
        any = 1;
        if (alarm_fields[i*FW +: 7] != now_fields[i*7 +: 7]) ok = 0;
      end
    end
    return (any == 1 && ok == 1 && !battery) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_stat = 0; m_cnt = 0;
    end else begin
      int h, e;
      h = ref_hit();
      e = (h == 1 && m_prev == 0) ? 1 : 0;
      m_prev = h;
      if (e == 1) m_stat = 1;
      else if ((stat_wr && !stat_wr_val) || (stat_rd && auto_clr)) m_stat = 0;
      if (battery) m_cnt = 0;
      else if (e == 1 && pulse_mode) m_cnt = PMS;
      else if (tick_1k && m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the edges
  initial begin
    forever begin
      logic e_irq;
      @(negedge clk); #2;
      if (battery) e_irq = 1;
      else if (pulse_mode) e_irq = (m_cnt == 0);
      else e_irq = (m_stat == 0);
      check(cur_req, alm_stat, m_stat[0], "alm_stat");
      check(cur_req, irq_n, e_irq, "irq_n");
    end
  end

  // 1 kHz enable, scaled to every fourth cycle
  initial begin
    int d = 0;
    forever begin
      @(negedge clk);
      d++;
      tick_1k = (d % 4 == 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NF*(FW-1)-1:0] tv(input int s, mi, h, d, mo, w);
    return {7'(w), 7'(mo), 7'(d), 7'(h), 7'(mi), 7'(s)};
  endfunction

  function automatic logic [7:0] af(input bit en, input int v);
    return {en, 7'(v)};
  endfunction

  task automatic wr0();
    stat_wr = 1; stat_wr_val = 0; cyc(1); stat_wr = 0;
  endtask

  initial begin
    cyc(3);
    cur_req = "R11";
    check("R11", irq_n, 1'b1, "irq_n after reset");
    check("R11", alm_stat, 1'b0, "alm_stat after reset");
    rst_n = 1;
    cyc(2);

    // R1: only second and minute enabled; hour differs
    cur_req = "R1";
    alarm_fields = {af(0,3), af(0,5), af(0,12), af(0,9), af(1,30), af(1,10)};
    now_fields = tv(9, 30, 1, 1, 1, 1); cyc(3);
    now_fields = tv(10, 30, 22, 7, 11, 4); cyc(4);
    check("R1", alm_stat, 1'b1, "masked match");
    cur_req = "R4";
    stat_wr = 1; stat_wr_val = 1; cyc(1); stat_wr = 0; cyc(2);
    check("R4", alm_stat, 1'b1, "write one keeps");
    wr0(); cyc(2);
    check("R4", alm_stat, 1'b0, "write zero clears");

    // R7: held match gives one event
    cur_req = "R7";
    cyc(10);
    check("R7", alm_stat, 1'b0, "held match no re-set");

    // R1: day-of-week only, then all six fields
    cur_req = "R1";
    alarm_fields = {af(1,2), af(0,0), af(0,0), af(0,0), af(0,0), af(0,0)};
    now_fields = tv(0, 0, 0, 0, 0, 3); cyc(3);
    now_fields = tv(44, 1, 5, 6, 7, 2); cyc(3);
    wr0(); cyc(2);
    alarm_fields = {af(1,6), af(1,12), af(1,31), af(1,23), af(1,59), af(1,58)};
    now_fields = tv(58, 59, 23, 31, 12, 5); cyc(3);
    now_fields = tv(58, 59, 23, 31, 12, 6); cyc(3);
    check("R1", alm_stat, 1'b1, "all fields match");
    wr0(); cyc(2);

    // R2: no fields enabled, equal values
    cur_req = "R2";
    alarm_fields = {af(0,1), af(0,1), af(0,1), af(0,1), af(0,1), af(0,1)};
    now_fields = tv(2, 2, 2, 2, 2, 2); cyc(2);
    now_fields = tv(1, 1, 1, 1, 1, 1); cyc(5);
    check("R2", alm_stat, 1'b0, "no enabled field");

    // R5: read clears only with auto_clr
    cur_req = "R5";
    alarm_fields = {af(0,0), af(0,0), af(0,0), af(0,0), af(0,0), af(1,20)};
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(3);
    stat_rd = 1; cyc(1); stat_rd = 0; cyc(2);
    check("R5", alm_stat, 1'b1, "read without auto_clr");
    auto_clr = 1; stat_rd = 1; cyc(1); stat_rd = 0; cyc(2);
    check("R5", alm_stat, 1'b0, "read with auto_clr");

    // R10: event and clear in same cycle
    cur_req = "R10";
    now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); stat_rd = 1; cyc(1); stat_rd = 0; cyc(2);
    check("R10", alm_stat, 1'b1, "set beats read clear");
    auto_clr = 0;
    now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); wr0(); cyc(2);
    check("R10", alm_stat, 1'b1, "set beats write clear");
    wr0(); cyc(2);

    // R6: pulsed mode width
    cur_req = "R6";
    pulse_mode = 1;
    now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(3);
    check("R6", irq_n, 1'b0, "pulse started");
    wr0(); cyc(2);
    check("R6", irq_n, 1'b0, "pulse ignores status");
    cyc(PMS * 4 + 8);
    check("R6", irq_n, 1'b1, "pulse ended");

    // R8: restart during pulse
    cur_req = "R8";
    now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(PMS * 2);
    now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(PMS * 3);
    check("R8", irq_n, 1'b0, "restarted pulse still low");
    cyc(PMS + 10);

    // R9: battery mode
    cur_req = "R9";
    now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(20);
    battery = 1; cyc(5);
    check("R9", irq_n, 1'b1, "irq high on battery");
    wr0(); now_fields = tv(21, 0, 0, 0, 0, 0); cyc(2);
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(4);
    check("R9", alm_stat, 1'b0, "no event on battery");
    battery = 0; pulse_mode = 0; cyc(4);
    pulse_mode = 1; now_fields = tv(21, 0, 0, 0, 0, 0); cyc(4);

    cur_req = "R3";
    pulse_mode = 0; wr0();
    now_fields = tv(20, 0, 0, 0, 0, 0); cyc(3);
    check("R3", irq_n, 1'b0, "latched irq low");
    cyc(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule